// File: doc/BRIEF.md
# Serial Flash Direct-Read Window

This block lets a bus master read up to four serial flash devices as if they were plain read-only memory. A word read at a bus address is turned into a standard single-line serial read transaction. The two upper address bits pick the device, which gives each device a fixed 16 MiB slice. The remaining 24 bits are the address inside the device. The four data bytes that come back are packed little-endian into a 32-bit word and returned with a one-cycle response pulse.

Two configuration inputs, both counted in 512 KiB units, limit what may be read. One sets the total size of the window and the other sets the usable size of each device. A read outside either limit gets an immediate error response and never touches the serial pins.

A stall input lets a software-driven command engine claim the serial bus. A read already in flight runs to completion. After that, no new read is accepted, and a grant output tells the engine that the bus is free.

Top module: `flash_rdwin`

## Requirements
- R1: After reset all chip selects are high (deselected), the serial clock is low, no response is pending and `rd_ready` is high.
- R2: An accepted in-range read pulls low only chip select `rd_addr[25:24]`. At no time is more than one chip select low.
- R3: The transaction sends opcode 0x03 followed by `rd_addr[23:0]`, most significant bit first. It uses mode 0: the clock idles low, MOSI changes while the clock is low and MISO is sampled on the rising edge. Each bit takes two system clocks, and the clock toggles only while a chip select is low.
- R4: The four bytes read from flash addresses A, A+1, A+2 and A+3 are returned in `rsp_data` bits [7:0], [15:8], [23:16] and [31:24] respectively.
- R5: For an in-range read accepted at a clock edge, `rsp_valid` pulses with `rsp_err` low exactly 128 clock edges later. The chip select is released in that same cycle, and `rd_ready` is high in that same cycle if stall is low.
- R6: A read at or above `cfg_win` × 512 KiB gets a one-cycle error response on the cycle after acceptance, with `rsp_data` zero and no chip select or clock activity.
- R7: A read whose in-device offset `rd_addr[23:0]` is at or above `cfg_dev` × 512 KiB gets the same error response as in R6.
- R8: A read is accepted only in a cycle where `rd_req` and `rd_ready` are both high. `rd_ready` is high exactly when no transaction is running and `stall` is low. A request at any other time has no effect.
- R9: Raising `stall` during a transaction does not cut it short. `stall_gnt` is high exactly when `stall` is high and no transaction is running, and while it is high all chip selects stay high and the clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | 26 | Byte address in the window |
| rd_ready | output | 1 | A request is accepted this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an out-of-range rejection |
| rsp_data | output | 32 | Little-endian read data, zero on error |
| cfg_win | input | 8 | Total window size in 512 KiB units |
| cfg_dev | input | 6 | Per-device size in 512 KiB units |
| stall | input | 1 | Command engine wants the serial bus |
| stall_gnt | output | 1 | Serial bus is idle and held for the engine |
| spi_cs_n | output | 4 | Active-low device selects |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
An error response is due one clock edge after the accepting edge. A good response and the release of the chip select are due 128 edges after it. `rd_ready` and `stall_gnt` follow `stall` in the same cycle once no transaction is running. The bench keeps a behavioural countdown that is advanced at each rising edge from the acceptance condition. It compares every output against that countdown at the following falling edge, so each result is sampled in the cycle it is due and not one cycle early or late. A flash model reacts to the serial clock edges, checks the command and address bits it receives, and supplies data bytes computed from the address.

// File: rtl/flash_rdwin_pkg.sv
package flash_rdwin_pkg;

    localparam int          OP_W     = 8;
    localparam logic [7:0]  READ_OP  = 8'h03;
    localparam int          WORD_W   = 32;

    typedef struct packed {
        logic              err;
        logic [WORD_W-1:0] data;
    } rsp_t;

    // bytes arrive first-byte-in-MSB; bus wants first byte in [7:0]
    function automatic logic [WORD_W-1:0] to_le(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W/8; b++)
            r[b*8 +: 8] = w[WORD_W-8-b*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/flash_rdwin_decode.sv
module flash_rdwin_decode #(
    parameter int CS_W     = 2,
    parameter int FLASH_AW = 24,
    parameter int UNIT_LG  = 19,
    parameter int WIN_W    = CS_W + FLASH_AW - UNIT_LG + 1,
    parameter int DEV_W    = FLASH_AW - UNIT_LG + 1
) (
    input  logic [CS_W+FLASH_AW-1:0] addr,
    input  logic [WIN_W-1:0]         cfg_win,
    input  logic [DEV_W-1:0]         cfg_dev,
    output logic [CS_W-1:0]          sel,
    output logic [FLASH_AW-1:0]      faddr,
    output logic                     in_range
);
    localparam int AW = CS_W + FLASH_AW;

    logic [AW:0]       win_lim;
    logic [FLASH_AW:0] dev_lim;

    always_comb begin
        sel      = addr[AW-1 -: CS_W];
        faddr    = addr[FLASH_AW-1:0];
        win_lim  = {cfg_win, {UNIT_LG{1'b0}}};
        dev_lim  = {cfg_dev, {UNIT_LG{1'b0}}};
        in_range = ({1'b0, addr} < win_lim) && ({1'b0, faddr} < dev_lim);
    end
endmodule

// File: rtl/flash_rdwin_shifter.sv
module flash_rdwin_shifter #(
    parameter int TX_BITS = 32,
    parameter int RX_BITS = 32,
    localparam int TOT    = TX_BITS + RX_BITS,
    localparam int CNT_W  = $clog2(TOT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TX_BITS-1:0] tx_word,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic               busy,
    output logic               done,
    output logic [RX_BITS-1:0] rx_word
);
    logic [TX_BITS-1:0] tx_q;
    logic [CNT_W-1:0]   bit_q;
    logic               hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_word <= '0;
            bit_q   <= '0;
            hi_q    <= 1'b0;
            sck     <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else if (start) begin
            tx_q  <= tx_word;
            bit_q <= '0;
            hi_q  <= 1'b0;
            sck   <= 1'b0;
            busy  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (!hi_q) begin
                    sck     <= 1'b1;
                    hi_q    <= 1'b1;
                    rx_word <= {rx_word[RX_BITS-2:0], miso};
                end else begin
                    sck  <= 1'b0;
                    hi_q <= 1'b0;
                    tx_q <= {tx_q[TX_BITS-2:0], 1'b0};
                    if (bit_q == CNT_W'(TOT - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
            end
        end
    end

    assign mosi = tx_q[TX_BITS-1];
endmodule

// File: rtl/flash_rdwin.sv
module flash_rdwin
    import flash_rdwin_pkg::*;
#(
    parameter int CS_W     = 2,
    parameter int FLASH_AW = 24,
    parameter int UNIT_LG  = 19,
    localparam int NCS     = 1 << CS_W,
    localparam int AW      = CS_W + FLASH_AW,
    localparam int WIN_W   = AW - UNIT_LG + 1,
    localparam int DEV_W   = FLASH_AW - UNIT_LG + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_data,
    input  logic [WIN_W-1:0]  cfg_win,
    input  logic [DEV_W-1:0]  cfg_dev,
    input  logic              stall,
    output logic              stall_gnt,
    output logic [NCS-1:0]    spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic [CS_W-1:0]     sel, sel_q;
    logic [FLASH_AW-1:0] faddr;
    logic                ok, err_q, busy, done, accept;
    logic [WORD_W-1:0]   rx;
    rsp_t                rsp;

    flash_rdwin_decode #(
        .CS_W(CS_W), .FLASH_AW(FLASH_AW), .UNIT_LG(UNIT_LG),
        .WIN_W(WIN_W), .DEV_W(DEV_W)
    ) u_dec (
        .addr(rd_addr), .cfg_win(cfg_win), .cfg_dev(cfg_dev),
        .sel(sel), .faddr(faddr), .in_range(ok)
    );

    assign rd_ready  = !busy && !stall;
    assign stall_gnt = stall && !busy;
    assign accept    = rd_req && rd_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= accept && !ok;
            if (accept && ok)
                sel_q <= sel;
        end
    end

    flash_rdwin_shifter #(
        .TX_BITS(OP_W + FLASH_AW), .RX_BITS(WORD_W)
    ) u_shf (
        .clk(clk), .rst(rst), .start(accept && ok),
        .tx_word({READ_OP, faddr}), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi), .busy(busy),
        .done(done), .rx_word(rx)
    );

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign spi_cs_n[i] = !(busy && sel_q == CS_W'(i));
    end

    always_comb begin
        rsp.err  = err_q;
        rsp.data = done ? to_le(rx) : '0;
    end

    assign rsp_valid = done || err_q;
    assign rsp_err   = rsp.err;
    assign rsp_data  = rsp.data;
endmodule

// File: rtl/flash_rdwin_chk.sv
module flash_rdwin_chk #(
    parameter int CS_W     = 2,
    parameter int FLASH_AW = 24,
    parameter int UNIT_LG  = 19,
    localparam int NCS     = 1 << CS_W,
    localparam int AW      = CS_W + FLASH_AW,
    localparam int WIN_W   = AW - UNIT_LG + 1,
    localparam int DEV_W   = FLASH_AW - UNIT_LG + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_req,
    input logic [AW-1:0]    rd_addr,
    input logic             rd_ready,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [31:0]      rsp_data,
    input logic [WIN_W-1:0] cfg_win,
    input logic [DEV_W-1:0] cfg_dev,
    input logic             stall_gnt,
    input logic [NCS-1:0]   spi_cs_n,
    input logic             spi_sck
);
    logic oor;
    assign oor = ({1'b0, rd_addr} >= {cfg_win, {UNIT_LG{1'b0}}}) ||
                 ({1'b0, rd_addr[FLASH_AW-1:0]} >= {cfg_dev, {UNIT_LG{1'b0}}});

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~spi_cs_n));

    // R3
    sck_framed_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> !(&spi_cs_n));

    // R6
    err_next_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ready && oor) |=> (rsp_valid && rsp_err));

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> ((&spi_cs_n) && rsp_data == '0));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        !(&spi_cs_n) |-> !rd_ready);

    // R9
    gnt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stall_gnt |-> ((&spi_cs_n) && !spi_sck));

    // R5
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> ((&spi_cs_n) && $past(!(&spi_cs_n))));
endmodule

bind flash_rdwin flash_rdwin_chk #(
    .CS_W(CS_W), .FLASH_AW(FLASH_AW), .UNIT_LG(UNIT_LG)
) u_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data), .cfg_win(cfg_win), .cfg_dev(cfg_dev),
    .stall_gnt(stall_gnt), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck)
);

// File: tb/flash_rdwin_bench.sv
`timescale 1ns/1ps
module flash_rdwin_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [25:0] rd_addr = '0;
    logic        rd_ready, rsp_valid, rsp_err, stall_gnt;
    logic [31:0] rsp_data;
    logic [7:0]  cfg_win = 8'd128;
    logic [5:0]  cfg_dev = 6'd32;
    logic        stall = 1'b0;
    logic [3:0]  spi_cs_n;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    flash_rdwin u_flash_rdwin (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_data(rsp_data), .cfg_win(cfg_win), .cfg_dev(cfg_dev),
        .stall(stall), .stall_gnt(stall_gnt), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit started = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] fbyte(input int cs, input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'(cs * 91) ^ 8'ha7;
    endfunction

    function automatic logic [31:0] fword(input int cs, input logic [23:0] a);
        return {fbyte(cs, a + 24'd3), fbyte(cs, a + 24'd2), fbyte(cs, a + 24'd1), fbyte(cs, a)};
    endfunction

    // behavioural reference: countdown per accepted read
    int          m_busy = 0;
    int          m_cs = -1;
    bit          m_rsp_v = 1'b0;
    bit          m_rsp_err = 1'b0;
    logic [31:0] m_rsp_d = '0;
    logic [31:0] m_pend = '0;
    logic [33:0] exp_cmd[$];

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cs = -1; m_rsp_v = 0; m_rsp_err = 0;
        end else begin
            m_rsp_v = 0; m_rsp_err = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    m_rsp_v = 1; m_rsp_d = m_pend; m_cs = -1;
                end
            end else if (rd_req && !stall) begin
                if (int'(rd_addr) >= int'(cfg_win) * 524288 ||
                    int'(rd_addr[23:0]) >= int'(cfg_dev) * 524288) begin
                    m_rsp_v = 1; m_rsp_err = 1; m_rsp_d = '0;
                end else begin
                    m_busy = 128;
                    m_cs = int'(rd_addr[25:24]);
                    m_pend = fword(m_cs, rd_addr[23:0]);
                    exp_cmd.push_back({rd_addr[25:24], 8'h03, rd_addr[23:0]});
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && started) begin
            logic [3:0] exp_cs;
            exp_cs = (m_cs < 0) ? 4'hF : ~(4'b0001 << m_cs);
            chk(spi_cs_n == exp_cs, "R2 chip select", 64'(spi_cs_n), 64'(exp_cs));
            chk(rd_ready == (m_busy == 0 && !stall), "R8 ready", 64'(rd_ready), 64'(m_busy == 0 && !stall));
            chk(stall_gnt == (stall && m_busy == 0), "R9 grant", 64'(stall_gnt), 64'(stall && m_busy == 0));
            chk(rsp_valid == m_rsp_v, "R5 response timing", 64'(rsp_valid), 64'(m_rsp_v));
            if (m_rsp_v) begin
                chk(rsp_err == m_rsp_err, "R6 R7 error flag", 64'(rsp_err), 64'(m_rsp_err));
                chk(rsp_data == m_rsp_d, "R4 data", 64'(rsp_data), 64'(m_rsp_d));
            end
            if (m_cs < 0)
                chk(spi_sck == 1'b0, "R3 idle clock", 64'(spi_sck), 64'd0);
        end
    end

    // flash device model
    int          f_cnt = 0;
    int          f_cs = 0;
    logic [31:0] f_sh = '0;
    logic [23:0] f_addr = '0;
    wire         all_hi = &spi_cs_n;

    always @(negedge all_hi) begin
        f_cnt = 0;
        for (int i = 0; i < 4; i++) if (!spi_cs_n[i]) f_cs = i;
    end

    always @(posedge all_hi) spi_miso = 1'b0;

    always @(posedge spi_sck) begin
        if (f_cnt < 32) f_sh = {f_sh[30:0], spi_mosi};
        f_cnt++;
        if (f_cnt == 32) begin
            logic [33:0] e;
            f_addr = f_sh[23:0];
            if (exp_cmd.size() == 0) begin
                chk(1'b0, "R3 unexpected command", 64'(f_sh), 64'd0);
            end else begin
                e = exp_cmd.pop_front();
                chk({2'(f_cs), f_sh} == e, "R3 command bits", 64'({2'(f_cs), f_sh}), 64'(e));
            end
        end
    end

    always @(negedge spi_sck) begin
        if (f_cnt >= 32 && f_cnt < 64) begin
            int k;
            logic [7:0] b;
            k = f_cnt - 32;
            b = fbyte(f_cs, f_addr + 24'(k / 8));
            spi_miso = b[7 - (k % 8)];
        end
    end

    task automatic issue(input logic [25:0] a);
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        rd_addr = a;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic do_read(input logic [25:0] a);
        issue(a);
        repeat (132) @(negedge clk);
    endtask

    task automatic poke(input logic [25:0] a);
        rd_addr = a;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd0);
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 4'hF, "R1 cs after reset", 64'(spi_cs_n), 64'hF);
        chk(spi_sck == 1'b0, "R1 sck after reset", 64'(spi_sck), 64'd0);
        chk(rsp_valid == 1'b0, "R1 no response", 64'(rsp_valid), 64'd0);
        chk(rd_ready == 1'b1, "R1 ready", 64'(rd_ready), 64'd1);
        started = 1'b1;

        // R2 R3 R4 R5 reads on each device
        do_read({2'd0, 24'h000100});
        do_read({2'd1, 24'h123456});
        do_read({2'd3, 24'hFFFFFC});
        do_read({2'd2, 24'h00AB10});

        // R6 window limit at 32 MiB
        cfg_win = 8'd64;
        do_read({2'd2, 24'h000000});
        do_read({2'd1, 24'hFFFFF0});
        cfg_win = 8'd128;

        // R7 device limit at 8 MiB
        cfg_dev = 6'd16;
        do_read({2'd0, 24'h800000});
        do_read({2'd3, 24'h7FFFFC});
        cfg_dev = 6'd32;

        // R8 request during a transfer is dropped
        issue({2'd1, 24'h000040});
        repeat (10) @(negedge clk);
        poke({2'd2, 24'h000080});
        repeat (130) @(negedge clk);

        // R9 stall while idle holds off requests
        stall = 1'b1;
        @(negedge clk);
        poke({2'd0, 24'h000010});
        repeat (20) @(negedge clk);
        stall = 1'b0;

        // R9 stall mid-transfer: finishes, then grant
        issue({2'd2, 24'h345678});
        repeat (30) @(negedge clk);
        stall = 1'b1;
        repeat (20) @(negedge clk);
        poke({2'd3, 24'h000000});
        repeat (110) @(negedge clk);
        poke({2'd3, 24'h000000});
        repeat (5) @(negedge clk);
        stall = 1'b0;
        do_read({2'd3, 24'h00FF00});

        chk(exp_cmd.size() == 0, "R3 all commands seen", 64'(exp_cmd.size()), 64'd0);
        summary();
    end
endmodule